// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the slave side of the SMBus alert-response procedure. When a rising edge on the combined alert sources arrives, it latches a pending alert and pulls an open-drain alert line low. A host that sees the line low issues a START followed by the alert response address with the read bit set. While an alert is pending, the block acknowledges that byte and shifts out its own 7-bit address followed by a 1. Several devices may answer at once, so it arbitrates bit by bit as it sends.

The block works on SCL and SDA samples that are already synchronised to `clk`. It drives SDA only through a pull-down enable. If it releases SDA for a 1 and reads back a 0, it has lost arbitration: it drops out at once and keeps its alert pending. If it sends all eight bits without losing, it releases the alert line. It then ignores further alert-response requests until a new alert event arms it again.

Top module: `smb_alert_resp`

## Requirements
- R1: During and right after reset, neither the SDA pull-down nor the alert pull-down is active.
- R2: A one-cycle high pulse on `new_alert` makes `alert_pull` go high on the next clock edge. It stays high until the block wins an alert-response transfer.
- R3: After a START, if the received byte equals 8'h19 (address 7'b0001100, read bit 1) and an alert is pending, `sda_pull` goes high after the SCL falling edge that ends the eighth bit. It stays high through the ninth (acknowledge) clock.
- R4: After the acknowledge, the block sends the byte 8'hC9 (address 7'b1100100, then a 1), MSB first. `sda_pull` only changes on a clock edge where SCL was sampled low.
- R5: If the block releases SDA for a 1 but samples SDA low on an SCL rising edge, it stops driving for the rest of that transfer. Its alert stays pending.
- R6: When the block sends the last bit without losing arbitration, `alert_pull` drops on the clock edge that detects that SCL rise. A later alert-response byte is not acknowledged.
- R7: A new `new_alert` pulse after a completed transfer re-arms the block, so the next alert-response byte is acknowledged again.
- R8: A byte other than 8'h19 (another address, or the response address with the write bit), or 8'h19 with no alert pending, is not acknowledged. The block waits for the next START.
- R9: A STOP, or a repeated START, in the middle of a byte aborts the transfer and leaves the alert pending. A repeated START begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired-AND bus value) |
| new_alert | input | 1 | One-cycle pulse on a rising edge of the OR of the alert sources |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| alert_pull | output | 1 | 1 = pull the alert line low |

## Verification
The assertions assume that every party on the bus obeys the bus rules. SDA moves only while SCL is low, except for the START and STOP edges. No master issues a START or STOP while this block holds SDA low. The bench drives SCL and SDA from tasks that change data only in the low phase, with several clocks per phase. Its SDA input is the wired-AND of master, rival and this block. A rival responder with a lower address makes the block lose arbitration, and one with a higher address makes the rival lose. Aborts are placed only in the address byte, where SDA is free.

// File: rtl/smb_alert_resp.sv
module smb_alert_resp #(
  parameter logic [6:0] OWN_ADDR = 7'b1100100,
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic new_alert,
  output logic sda_pull,
  output logic alert_pull
);
  localparam logic [7:0] ARA_BYTE = {ARA_ADDR, 1'b1};
  localparam logic [7:0] TX_BYTE  = {OWN_ADDR, 1'b1};

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_ACK, S_SEND} st_t;

  st_t        st;
  logic       scl_q, sda_q, pending;
  logic [2:0] cnt;
  logic [7:0] sh;

  wire rise  = scl_i & ~scl_q;
  wire fall  = ~scl_i & scl_q;
  wire start = scl_i & scl_q & sda_q & ~sda_i;
  wire stop  = scl_i & scl_q & ~sda_q & sda_i;
  wire [7:0] rx = {sh[6:0], sda_i};
  wire tx_bit = TX_BYTE[3'd7 - cnt];
  wire lost = (st == S_SEND) & rise & tx_bit & ~sda_i;
  wire won  = (st == S_SEND) & rise & ~lost & (cnt == 3'd7);

  assign alert_pull = pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pending <= 1'b0;
    else if (new_alert) pending <= 1'b1;
    else if (won)       pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cnt      <= 3'd0;
      sh       <= 8'd0;
      sda_pull <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start) begin
        st       <= S_ADDR;
        cnt      <= 3'd0;
        sda_pull <= 1'b0;
      end else if (stop) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (rise) begin
              sh  <= rx;
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7)
                st <= (rx == ARA_BYTE && pending) ? S_ACK : S_IDLE;
            end
          S_ACK:
            if (fall) begin
              if (!sda_pull) sda_pull <= 1'b1;
              else begin
                st       <= S_SEND;
                cnt      <= 3'd0;
                sda_pull <= ~TX_BYTE[7];
              end
            end
          S_SEND:
            if (lost || won) begin
              st       <= S_IDLE;
              sda_pull <= 1'b0;
            end else if (rise) cnt <= cnt + 3'd1;
            else if (fall)     sda_pull <= ~tx_bit;
          default: ;
        endcase
      end
    end
  end
endmodule

module smb_alert_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic new_alert,
  input logic sda_pull,
  input logic alert_pull
);
  p_pull_moves_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_i));

  p_alert_rise_from_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_pull) |-> $past(new_alert));

  p_drive_needs_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> alert_pull);

  p_release_on_won_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_pull) |-> ($past(scl_i) && $past(sda_i) && !$past(new_alert)));
endmodule

bind smb_alert_resp smb_alert_resp_chk u_chk (.*);

// File: tb/smb_alert_resp_test.sv
`timescale 1ns/1ps
module smb_alert_resp_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, mst_sda = 1'b1, rival_sda = 1'b1, new_alert = 1'b0;
  logic sda_pull, alert_pull;
  wire  sda_bus = mst_sda & rival_sda & ~sda_pull;

  logic exp_pull = 1'b0, exp_alert = 1'b0, pend_m = 1'b0;
  int   checks = 0, fails = 0;
  string cur_req = "R1";
  localparam logic [7:0] ARA_RD = 8'h19;
  localparam logic [7:0] TX     = 8'hC9;

  smb_alert_resp uut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
                      .new_alert(new_alert), .sda_pull(sda_pull), .alert_pull(alert_pull));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    checks++;
    if (sda_pull !== exp_pull || alert_pull !== exp_alert) begin
      fails++;
      $display("FAIL %s per-clock: sda_pull=%b alert_pull=%b expected %b %b",
               cur_req, sda_pull, alert_pull, exp_pull, exp_alert);
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c;
    scl = 1'b0; hold(2); mst_sda = 1'b1; rival_sda = 1'b1; hold(2);
    scl = 1'b1; hold(2); mst_sda = 1'b0; hold(4);
  endtask

  task automatic stop_c;
    scl = 1'b0; exp_pull = 1'b0; hold(2); mst_sda = 1'b0; rival_sda = 1'b1; hold(2);
    scl = 1'b1; hold(2); mst_sda = 1'b1; hold(4);
  endtask

  task automatic clk_bit(input logic m, input logic r, input logic ep, input logic clr);
    scl = 1'b0; exp_pull = ep; hold(2);
    mst_sda = m; rival_sda = r; hold(2);
    scl = 1'b1; if (clr) exp_alert = 1'b0; hold(4);
  endtask

  task automatic pulse_alert;
    new_alert = 1'b1; exp_alert = 1'b1; pend_m = 1'b1; hold(1);
    new_alert = 1'b0; hold(2);
  endtask

  task automatic ara(input logic [7:0] ab, input logic use_rival, input logic [7:0] rb_byte);
    logic ack, active, ractive;
    start_c;
    for (int i = 0; i < 8; i++) clk_bit(ab[7-i], 1'b1, 1'b0, 1'b0);
    ack = (ab == ARA_RD) && pend_m;
    clk_bit(1'b1, 1'b1, ack, 1'b0);
    chk(sda_bus, ~ack, ack ? "R3 ack low" : "R8 no ack");
    if (ack) begin
      active = 1'b1; ractive = use_rival;
      for (int i = 0; i < 8; i++) begin
        logic ob, rb, ep, bus, win;
        ob  = TX[7-i];
        rb  = ractive ? rb_byte[7-i] : 1'b1;
        ep  = active & ~ob;
        bus = rb & ~ep;
        win = active && (i == 7) && bus;
        clk_bit(1'b1, rb, ep, win);
        chk(sda_bus, bus, use_rival ? "R5 arbitration bus bit" : "R4 sent bit");
        if (active && ob && !bus) active = 1'b0;
        if (ractive && rb && !bus) ractive = 1'b0;
        if (win) pend_m = 1'b0;
      end
      clk_bit(1'b1, 1'b1, 1'b0, 1'b0);
    end
    stop_c;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    hold(4);
    chk(sda_pull, 1'b0, "R1 reset sda"); chk(alert_pull, 1'b0, "R1 reset alert");
    rst_n = 1'b1; hold(4);

    cur_req = "R8";
    ara(ARA_RD, 1'b0, 8'hFF);
    chk(alert_pull, 1'b0, "R8 no pending stays idle");

    cur_req = "R2";
    pulse_alert; hold(10);
    chk(alert_pull, 1'b1, "R2 alert held");

    cur_req = "R8";
    ara(8'hC8, 1'b0, 8'hFF);
    ara(8'h18, 1'b0, 8'hFF);
    chk(alert_pull, 1'b1, "R8 alert still pending");

    cur_req = "R9";
    start_c;
    for (int i = 0; i < 3; i++) clk_bit(ARA_RD[7-i], 1'b1, 1'b0, 1'b0);
    stop_c;
    chk(alert_pull, 1'b1, "R9 after stop abort");
    start_c;
    for (int i = 0; i < 4; i++) clk_bit(ARA_RD[7-i], 1'b1, 1'b0, 1'b0);
    cur_req = "R5";
    ara(ARA_RD, 1'b1, 8'hC5);
    chk(alert_pull, 1'b1, "R5 lost keeps alert");
    chk(sda_pull, 1'b0, "R5 released after loss");

    cur_req = "R4";
    ara(ARA_RD, 1'b0, 8'hFF);
    cur_req = "R6";
    chk(alert_pull, 1'b0, "R6 alert released after win");
    ara(ARA_RD, 1'b0, 8'hFF);
    chk(sda_pull, 1'b0, "R6 ignored after win");

    cur_req = "R7";
    pulse_alert;
    ara(ARA_RD, 1'b1, 8'hD1);
    chk(alert_pull, 1'b0, "R7 rearmed and won over higher rival");
    hold(10);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule